// File: doc/BRIEF.md
# Bordered Raster Timing Generator

This block produces the scan timing for a raster display. A horizontal counter runs across each line, and a vertical counter advances at the end of each line. From the two counters the block derives horizontal and vertical sync, a rectangular border band, and a display window that sits inside that band. The border band is filled with a programmable colour. When the blank control bit is set, the whole border box shows the border colour and the window is suppressed, so the output stream keeps running.

The host programs the block through a single write port. Each write goes into a shadow copy of the register. The shadow copy is moved into the live settings all at once, at the start of the next field, so a mode change never shows up part way through a field. While the live settings are disabled, the shadow is copied across on every clock.

Optional doublescan repeats each logical line twice. Optional interlace alternates a field flag and folds that flag into the reported row. At the start of every new field the block raises a one-cycle retrace pulse, which the host can use as an interrupt.

Top module: `raster_timing_gen`

## Requirements
- R1: A write with select 0 sets clocks per line from bits 15:0 and lines per field from bits 31:16. While enabled, `pix_x` counts 0 up to clocks-1 and then wraps, and the line counter counts 0 up to lines-1.
- R2: A write does not change the outputs during the current field. The new settings take effect together on the first cycle of the next field, and both counters are zero in that cycle.
- R3: Select 5 is the control word, with bit 0 as enable. While the live enable is clear, the position and all flags are zero and no sync is produced. In this state a write reaches the live settings one cycle after it is accepted.
- R4: `hsync` is high while the column is below the horizontal border start. `vsync` is high while the line is below the vertical border start.
- R5: Select 1 sets the horizontal border start from bits 31:16 and the stop from bits 15:0. Select 2 does the same for the vertical border. The border box covers start <= pos < stop on both axes. `border` is high inside the box and outside the window. `border_rgb` carries the colour (select 4, bits 23:0) while `border` is high and is zero otherwise.
- R6: Select 3 sets the window start line from bits 31:16 and the start column from bits 15:0. `active` is high inside the border box when the column and line are both at or past the window start.
- R7: Control bit 3 (blank) forces `active` low everywhere, and `border` then covers the whole border box.
- R8: Control bit 1 (doublescan) holds each line for two line periods, so a field lasts 2 x lines x clocks cycles.
- R9: Control bit 4 (interlace) makes `field` toggle at every field end, and `pix_y` becomes 2 x line + field. With interlace off, `field` is 0 and `pix_y` equals the line.
- R10: `vbl_irq` is high for exactly the first cycle of each field that follows a completed field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| wr_en | input | 1 | register write strobe |
| wr_sel | input | 3 | register select |
| wr_data | input | 32 | register write data |
| pix_x | output | CNT_W | current column |
| pix_y | output | CNT_W | current row (interlace-aware) |
| active | output | 1 | inside display window |
| border | output | 1 | inside border band |
| border_rgb | output | 24 | border colour when in the border, else zero |
| hsync | output | 1 | horizontal sync |
| vsync | output | 1 | vertical sync |
| field | output | 1 | interlace field flag |
| vbl_irq | output | 1 | one-cycle retrace pulse |

## Verification
The assertions check, on every cycle, the following properties:
- the column steps by one within a line;
- the live settings change only at a field start;
- the whole output stays silent while disabled;
- window and border never overlap, and blank keeps the window closed;
- the field flag and vertical sync are stable within a line;
- the retrace pulse lands only at counter origin.

Only the bench scenarios can show the rest: the exact wrap points for the programmed totals, the cycle on which a mid-field write becomes visible, the doubled field length, and the interlaced row numbering. For these, the bench compares against a model built from elapsed cycles.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
   localparam int REG_W  = 32;
   localparam int HALF_W = 16;
   localparam int RGB_W  = 24;
   localparam int SEL_W  = 3;

   localparam logic [SEL_W-1:0] SEL_TOTALS = 3'd0;
   localparam logic [SEL_W-1:0] SEL_HBORD  = 3'd1;
   localparam logic [SEL_W-1:0] SEL_VBORD  = 3'd2;
   localparam logic [SEL_W-1:0] SEL_WIN    = 3'd3;
   localparam logic [SEL_W-1:0] SEL_RGB    = 3'd4;
   localparam logic [SEL_W-1:0] SEL_CTRL   = 3'd5;

   localparam int CTRL_EN_BIT    = 0;
   localparam int CTRL_DS_BIT    = 1;
   localparam int CTRL_BLANK_BIT = 3;
   localparam int CTRL_IL_BIT    = 4;

   typedef struct packed {
      logic [HALF_W-1:0] vtotal;
      logic [HALF_W-1:0] htotal;
      logic [HALF_W-1:0] hb_start;
      logic [HALF_W-1:0] hb_stop;
      logic [HALF_W-1:0] vb_start;
      logic [HALF_W-1:0] vb_stop;
      logic [HALF_W-1:0] hw_start;
      logic [HALF_W-1:0] vw_start;
      logic [RGB_W-1:0]  rgb;
      logic              en;
      logic              dscan;
      logic              ilace;
      logic              blank;
   } cfg_t;
endpackage

// File: rtl/rtg_regbank.sv
module rtg_regbank
   import rtg_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic [REG_W-1:0] wr_data,
   input  logic             apply,
   output cfg_t             act
);
   cfg_t shd;
   logic wr_unused;

   assign wr_unused = &{1'b0, wr_data[31:24], wr_data[15:5], wr_data[2]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shd <= '0;
      end else if (wr_en) begin
         case (wr_sel)
            SEL_TOTALS: begin
               shd.vtotal <= wr_data[31:16];
               shd.htotal <= wr_data[15:0];
            end
            SEL_HBORD: begin
               shd.hb_start <= wr_data[31:16];
               shd.hb_stop  <= wr_data[15:0];
            end
            SEL_VBORD: begin
               shd.vb_start <= wr_data[31:16];
               shd.vb_stop  <= wr_data[15:0];
            end
            SEL_WIN: begin
               shd.vw_start <= wr_data[31:16];
               shd.hw_start <= wr_data[15:0];
            end
            SEL_RGB: shd.rgb <= wr_data[RGB_W-1:0];
            SEL_CTRL: begin
               shd.en    <= wr_data[CTRL_EN_BIT];
               shd.dscan <= wr_data[CTRL_DS_BIT];
               shd.blank <= wr_data[CTRL_BLANK_BIT];
               shd.ilace <= wr_data[CTRL_IL_BIT];
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 act <= '0;
      else if (apply || !act.en)  act <= shd;
   end
endmodule

// File: rtl/rtg_counters.sv
module rtg_counters #(
   parameter int CNT_W    = 12,
   parameter bit DSCAN_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [15:0]      htotal,
   input  logic [15:0]      vtotal,
   input  logic             dscan,
   input  logic             ilace,
   output logic [CNT_W-1:0] hcnt,
   output logic [CNT_W-1:0] vcnt,
   output logic             field,
   output logic             field_end,
   output logic             irq
);
   localparam int EXT_W = 17;

   logic line_end, line_adv, field_q;

   assign line_end = (EXT_W'(hcnt) + EXT_W'(1)) >= EXT_W'(htotal);

   generate
      if (DSCAN_EN) begin : g_dscan
         logic rep;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        rep <= 1'b0;
            else if (!en)      rep <= 1'b0;
            else if (line_end) rep <= dscan ? ~rep : 1'b0;
         end
         assign line_adv = line_end && (!dscan || rep);
      end else begin : g_single
         logic ds_unused;
         assign ds_unused = dscan;
         assign line_adv  = line_end;
      end
   endgenerate

   assign field_end = en && line_adv &&
                      ((EXT_W'(vcnt) + EXT_W'(1)) >= EXT_W'(vtotal));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hcnt    <= '0;
         vcnt    <= '0;
         field_q <= 1'b0;
         irq     <= 1'b0;
      end else if (!en) begin
         hcnt    <= '0;
         vcnt    <= '0;
         field_q <= 1'b0;
         irq     <= 1'b0;
      end else begin
         irq <= field_end;
         if (line_end) hcnt <= '0;
         else          hcnt <= hcnt + 1'b1;
         if (field_end)     vcnt <= '0;
         else if (line_adv) vcnt <= vcnt + 1'b1;
         if (field_end) field_q <= ilace ? ~field_q : 1'b0;
      end
   end

   assign field = field_q & ilace;
endmodule

// File: rtl/rtg_region.sv
module rtg_region
   import rtg_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input  cfg_t             cfg,
   input  logic [CNT_W-1:0] hcnt,
   input  logic [CNT_W-1:0] vcnt,
   input  logic             field,
   output logic [CNT_W-1:0] pix_y,
   output logic             active,
   output logic             border,
   output logic [RGB_W-1:0] border_rgb,
   output logic             hsync,
   output logic             vsync
);
   logic [HALF_W-1:0] hx, vy;
   logic in_box, in_win;

   assign hx = HALF_W'(hcnt);
   assign vy = HALF_W'(vcnt);

   assign in_box = (hx >= cfg.hb_start) && (hx < cfg.hb_stop) &&
                   (vy >= cfg.vb_start) && (vy < cfg.vb_stop);
   assign in_win = in_box && (hx >= cfg.hw_start) && (vy >= cfg.vw_start) && !cfg.blank;

   assign active     = cfg.en && in_win;
   assign border     = cfg.en && in_box && !in_win;
   assign border_rgb = border ? cfg.rgb : '0;
   assign hsync      = cfg.en && (hx < cfg.hb_start);
   assign vsync      = cfg.en && (vy < cfg.vb_start);
   assign pix_y      = cfg.ilace ? {vcnt[CNT_W-2:0], field} : vcnt;
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
   import rtg_pkg::*;
#(
   parameter int CNT_W    = 12,
   parameter bit DSCAN_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       wr_sel,
   input  logic [31:0]      wr_data,
   output logic [CNT_W-1:0] pix_x,
   output logic [CNT_W-1:0] pix_y,
   output logic             active,
   output logic             border,
   output logic [23:0]      border_rgb,
   output logic             hsync,
   output logic             vsync,
   output logic             field,
   output logic             vbl_irq
);
   generate
      if (CNT_W < 4 || CNT_W > HALF_W) begin : g_bad_cnt_w
         $error("CNT_W must lie between 4 and the register half width");
      end
   endgenerate

   cfg_t             act_cfg;
   logic [CNT_W-1:0] hcnt, vcnt;
   logic             field_end;

   rtg_regbank u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .apply(field_end), .act(act_cfg)
   );

   rtg_counters #(.CNT_W(CNT_W), .DSCAN_EN(DSCAN_EN)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en(act_cfg.en),
      .htotal(act_cfg.htotal), .vtotal(act_cfg.vtotal),
      .dscan(act_cfg.dscan), .ilace(act_cfg.ilace),
      .hcnt(hcnt), .vcnt(vcnt), .field(field),
      .field_end(field_end), .irq(vbl_irq)
   );

   rtg_region #(.CNT_W(CNT_W)) u_reg_dec (
      .cfg(act_cfg), .hcnt(hcnt), .vcnt(vcnt), .field(field),
      .pix_y(pix_y), .active(active), .border(border),
      .border_rgb(border_rgb), .hsync(hsync), .vsync(vsync)
   );

   assign pix_x = hcnt;
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker
   import rtg_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input cfg_t             act,
   input logic [CNT_W-1:0] hcnt,
   input logic [CNT_W-1:0] vcnt,
   input logic             field,
   input logic             active,
   input logic             border,
   input logic             hsync,
   input logic             vsync,
   input logic             vbl_irq
);
   p_hstep_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (act.en && $past(act.en) && hcnt != '0) |-> hcnt == CNT_W'($past(hcnt) + 1'b1));

   p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(act.en) && act != $past(act)) |-> (hcnt == '0 && vcnt == '0));

   p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !act.en |-> (!hsync && !vsync && !active && !border && hcnt == '0 && vcnt == '0));

   p_vsync_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (act.en && $past(act.en) && hcnt != '0) |-> vsync == $past(vsync));

   p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({active, border}));

   p_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
      act.blank |-> !active);

   p_field_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (act.en && $past(act.en) && hcnt != '0) |-> $stable(field));

   p_irq_origin_r10: assert property (@(posedge clk) disable iff (!rst_n)
      vbl_irq |-> (hcnt == '0 && vcnt == '0));
endmodule

bind raster_timing_gen rtg_checker #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .act(act_cfg), .hcnt(hcnt), .vcnt(vcnt),
   .field(field), .active(active), .border(border), .hsync(hsync),
   .vsync(vsync), .vbl_irq(vbl_irq)
);

// File: tb/raster_timing_gen_tb.sv
module raster_timing_gen_tb;
   import rtg_pkg::*;

   localparam int CNT_W = 12;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic [2:0]       wr_sel = '0;
   logic [31:0]      wr_data = '0;
   logic [CNT_W-1:0] pix_x, pix_y;
   logic             active, border, hsync, vsync, field, vbl_irq;
   logic [23:0]      border_rgb;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   cfg_t cur, pend;
   int   t = 0;
   bit   fq = 1'b0;
   bit   irq_q = 1'b0;

   always #5 clk = ~clk;

   raster_timing_gen #(.CNT_W(CNT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .pix_x(pix_x), .pix_y(pix_y), .active(active), .border(border),
      .border_rgb(border_rgb), .hsync(hsync), .vsync(vsync), .field(field),
      .vbl_irq(vbl_irq)
   );

   task automatic chk(string req, string what, longint got, longint exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s got %0h exp %0h (t=%0d)", req, what, got, exp, t);
      end
   endtask

   function automatic cfg_t decode_wr(cfg_t c, logic [2:0] sel, logic [31:0] d);
      cfg_t n = c;
      case (sel)
         3'd0: begin n.vtotal = d[31:16]; n.htotal = d[15:0]; end
         3'd1: begin n.hb_start = d[31:16]; n.hb_stop = d[15:0]; end
         3'd2: begin n.vb_start = d[31:16]; n.vb_stop = d[15:0]; end
         3'd3: begin n.vw_start = d[31:16]; n.hw_start = d[15:0]; end
         3'd4: n.rgb = d[23:0];
         3'd5: begin n.en = d[0]; n.dscan = d[1]; n.blank = d[3]; n.ilace = d[4]; end
         default: ;
      endcase
      return n;
   endfunction

   function automatic int field_len(cfg_t c);
      return int'(c.htotal) * int'(c.vtotal) * (c.dscan ? 2 : 1);
   endfunction

   task automatic check_cycle();
      int h, v, line, f, y;
      bit inbox, inwin;
      string tx, ty, ta;
      h = 0; v = 0;
      if (cur.en) begin
         h = t % int'(cur.htotal);
         line = t / int'(cur.htotal);
         v = cur.dscan ? line / 2 : line;
      end
      f = int'(cur.ilace & fq);
      y = cur.ilace ? 2 * v + f : v;
      inbox = cur.en && h >= int'(cur.hb_start) && h < int'(cur.hb_stop) &&
              v >= int'(cur.vb_start) && v < int'(cur.vb_stop);
      inwin = inbox && h >= int'(cur.hw_start) && v >= int'(cur.vw_start) && !cur.blank;
      tx = !cur.en ? "R3" : ((pend != cur) ? "R2" : "R1");
      ty = !cur.en ? "R3" : (cur.ilace ? "R9" : (cur.dscan ? "R8" : "R1"));
      ta = cur.blank ? "R7" : "R6";
      chk(tx, "pix_x", pix_x, h);
      chk(ty, "pix_y", pix_y, y);
      chk("R4", "hsync", hsync, cur.en && h < int'(cur.hb_start));
      chk("R4", "vsync", vsync, cur.en && v < int'(cur.vb_start));
      chk(ta, "active", active, inwin);
      chk("R5", "border", border, inbox && !inwin);
      chk("R5", "border_rgb", border_rgb, (inbox && !inwin) ? cur.rgb : 24'h0);
      chk("R9", "field", field, f);
      chk("R10", "vbl_irq", vbl_irq, irq_q);
   endtask

   task automatic advance();
      if (cur.en) begin
         irq_q = (t == field_len(cur) - 1);
         if (irq_q) begin
            fq  = cur.ilace ? ~fq : 1'b0;
            t   = 0;
            cur = pend;
         end else begin
            t++;
         end
      end else begin
         irq_q = 1'b0;
         fq    = 1'b0;
         t     = 0;
         cur   = pend;
      end
   endtask

   task automatic step(bit do_wr, logic [2:0] sel, logic [31:0] d);
      @(negedge clk);
      check_cycle();
      advance();
      wr_en = do_wr;
      wr_sel = sel;
      wr_data = d;
      if (do_wr) pend = decode_wr(pend, sel, d);
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) step(1'b0, 3'd0, 32'h0);
   endtask

   task automatic wr(logic [2:0] sel, logic [31:0] d);
      step(1'b1, sel, d);
   endtask

   function automatic logic [31:0] rand_value(logic [2:0] sel);
      int a, b;
      case (sel)
         3'd0: begin a = 8 + int'($urandom % 17); b = 4 + int'($urandom % 7); return {16'(b), 16'(a)}; end
         3'd1: begin a = int'($urandom % 6); b = a + int'($urandom % 20); return {16'(a), 16'(b)}; end
         3'd2: begin a = int'($urandom % 4); b = a + int'($urandom % 8); return {16'(a), 16'(b)}; end
         3'd3: begin a = int'($urandom % 16); b = int'($urandom % 8); return {16'(b), 16'(a)}; end
         3'd4: return $urandom;
         default: return 32'h1 | ($urandom & 32'h1A);
      endcase
   endfunction

   initial begin
      cur = '0;
      pend = '0;
      void'($urandom(32'h5EED_0042));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R3: reset state, everything quiet
      chk("R3", "reset pix_x", pix_x, 0);
      chk("R3", "reset flags", {active, border, hsync, vsync, field, vbl_irq}, 0);
      rst_n = 1'b1;

      // Directed mode: 20 clocks x 10 lines
      wr(3'd0, {16'd10, 16'd20});
      wr(3'd1, {16'd4, 16'd18});
      wr(3'd2, {16'd2, 16'd9});
      wr(3'd3, {16'd3, 16'd7});
      wr(3'd4, 32'h00A5_C33C);
      wr(3'd5, 32'h1);
      run(450);
      wr(3'd5, 32'h9);         // R7 blank, pending until field end
      run(300);
      wr(3'd5, 32'h3);         // R8 doublescan
      run(900);
      wr(3'd0, {16'd6, 16'd12}); // R2 totals change mid-field
      run(100);
      wr(3'd5, 32'h11);        // R9 interlace
      run(700);
      wr(3'd5, 32'h13);        // interlace with doublescan
      run(600);
      wr(3'd1, {16'd0, 16'd40}); // border starting at 0: no hsync
      run(400);

      // Constrained random register traffic
      for (int k = 0; k < 60; k++) begin
         logic [2:0] s;
         run(int'($urandom % 250));
         s = 3'($urandom % 6);
         wr(s, rand_value(s));
      end
      run(500);

      // R3: disable and confirm quiet outputs, then reprogram while off
      wr(3'd5, 32'h0);
      run(600);
      wr(3'd0, {16'd5, 16'd9});
      wr(3'd5, 32'h1);
      run(200);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule